// File: doc/BRIEF.md
# Secondary Interrupt Bank Controller

This block collects up to eighteen single-bit interrupt sources and presents them to two independent hosts, each on its own active-low interrupt line. Every source passes through an edge detector. A two-bit field selects the polarity of that detector, and both hosts share this field. A detected edge is latched into a status register for each line. The status bit then drives that line's output unless the line's mask register blocks that source.

Software reaches the registers through a simple byte-wide read and write port. A control bit selects how status is acknowledged. In one mode, reading a status byte clears the bits it returned. In the other mode, writing a one to a status bit clears it. An edge that arrives in the same cycle as an acknowledge is never lost.

Top module: `irq_bank_ctrl`

## Requirements
- R1: Source i has a two-bit trigger field in edge-select byte i/4, at bits (i mod 4)*2+1 and (i mod 4)*2. The upper bit arms rising-edge detection and the lower bit arms falling-edge detection; with both bits set, either edge triggers. A detected edge sets the source's status bit on both lines at the next clock edge.
- R2: A source whose trigger field is 00 never sets a status bit, whatever its input does.
- R3: A mask bit of 1 blocks that source on that line only. `irq_no[L]` is 0 while line L has a status bit set whose mask bit is 0. With the whole mask at ones, `irq_no[L]` stays 1.
- R4: With control bit 0 set to 1 (clear-on-read), a read of a status byte returns its bits and clears them. With control bit 0 at 0, reads leave status unchanged.
- R5: With control bit 0 at 0, writing 1 to a status bit clears it and writing 0 has no effect. With control bit 0 at 1, writes to status are ignored.
- R6: If a new edge for a source arrives in the same cycle as a clearing read or write of its status bit, the bit stays set.
- R7: For the default of 18 sources, the byte address map is: line 0 status 0..2, line 1 status 3..5, line 0 mask 6..8, line 1 mask 9..11, edge select 12..16, control 17. Multi-byte registers are little-endian, so byte b holds sources 8b..8b+7. Bits beyond the last source read as 0 and cannot be written.
- R8: After reset, every mask bit is 1, every status, edge-select and control bit is 0, and both `irq_no` bits are 1.
- R9: `rdata_o` carries the addressed byte in the cycle after `rd_en_i` and holds that value until the next read.
- R10: Status and mask are kept per line. Clearing or masking on one line leaves the other line unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| src_i | input | N_SRC | Synchronous interrupt source levels |
| rd_en_i | input | 1 | Register read strobe |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, registered |
| irq_no | output | 2 | Active-low interrupt, one per host line |

## Verification
A change on `src_i` reaches the status registers and `irq_no` one clock edge later. A register write takes effect at the edge that samples it. Read data appears on `rdata_o` at the edge after `rd_en_i`, and a clear-on-read takes effect at that same edge. The bench drives every stimulus on a falling edge and samples at the following falling edge, so each result is checked exactly one rising edge after its cause. The coincidence cases put the edge and the acknowledge in the same cycle and read the status back afterwards.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

  localparam int COR_BIT = 0;

  typedef enum logic [2:0] {
    REG_ST0,
    REG_ST1,
    REG_MK0,
    REG_MK1,
    REG_EDGE,
    REG_CTRL,
    REG_NONE
  } reg_region_e;

  function automatic int status_bytes(input int n);
    return (n + 7) / 8;
  endfunction

  function automatic int edge_bytes(input int n);
    return (2 * n + 7) / 8;
  endfunction

endpackage

// File: rtl/irq_edge_unit.sv
module irq_edge_unit #(
  parameter int N_SRC = 18,
  parameter int EB    = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_SRC-1:0]   src_i,
  input  logic [EB-1:0]      wr_be_i,
  input  logic [7:0]         wdata_i,
  output logic [2*N_SRC-1:0] sel_o,
  output logic [N_SRC-1:0]   ev_o
);

  logic [2*N_SRC-1:0] sel_q, sel_n;
  logic [N_SRC-1:0]   prev_q;

  always_comb begin
    sel_n = sel_q;
    for (int i = 0; i < 2 * N_SRC; i++) begin
      if (wr_be_i[i / 8]) sel_n[i] = wdata_i[i % 8];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= '0;
      prev_q <= '0;
    end else begin
      sel_q  <= sel_n;
      prev_q <= src_i;
    end
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    logic rise, fall;
    assign rise    = src_i[i] & ~prev_q[i];
    assign fall    = ~src_i[i] & prev_q[i];
    assign ev_o[i] = (sel_q[2*i+1] & rise) | (sel_q[2*i] & fall);
  end

  assign sel_o = sel_q;

endmodule

// File: rtl/irq_line_slice.sv
module irq_line_slice #(
  parameter int N_SRC = 18,
  parameter int NB    = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] ev_i,
  input  logic [N_SRC-1:0] clr_i,
  input  logic [NB-1:0]    mk_be_i,
  input  logic [7:0]       wdata_i,
  output logic [N_SRC-1:0] st_o,
  output logic [N_SRC-1:0] mk_o,
  output logic             irq_no
);

  logic [N_SRC-1:0] st_q, st_n, mk_q, mk_n;

  always_comb begin
    st_n = (st_q & ~clr_i) | ev_i;
    mk_n = mk_q;
    for (int i = 0; i < N_SRC; i++) begin
      if (mk_be_i[i / 8]) mk_n[i] = wdata_i[i % 8];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= '0;
      mk_q <= '1;
    end else begin
      st_q <= st_n;
      mk_q <= mk_n;
    end
  end

  assign st_o   = st_q;
  assign mk_o   = mk_q;
  assign irq_no = ~|(st_q & ~mk_q);

endmodule

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
  import irq_bank_pkg::*;
#(
  parameter int N_SRC  = 18,
  parameter int ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic [1:0]        irq_no
);

  localparam int SB     = status_bytes(N_SRC);
  localparam int EB     = edge_bytes(N_SRC);
  localparam int ST_PAD = SB * 8;
  localparam int EG_PAD = EB * 8;
  localparam logic [ADDR_W-1:0] ST1_BASE  = ADDR_W'(SB);
  localparam logic [ADDR_W-1:0] MK0_BASE  = ADDR_W'(2 * SB);
  localparam logic [ADDR_W-1:0] MK1_BASE  = ADDR_W'(3 * SB);
  localparam logic [ADDR_W-1:0] EDGE_BASE = ADDR_W'(4 * SB);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(4 * SB + EB);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  // address decode
  reg_region_e       region;
  logic [ADDR_W-1:0] offs;
  always_comb begin
    region = REG_NONE;
    offs   = '0;
    if (addr_i < ST1_BASE) begin
      region = REG_ST0;  offs = addr_i;
    end else if (addr_i < MK0_BASE) begin
      region = REG_ST1;  offs = addr_i - ST1_BASE;
    end else if (addr_i < MK1_BASE) begin
      region = REG_MK0;  offs = addr_i - MK0_BASE;
    end else if (addr_i < EDGE_BASE) begin
      region = REG_MK1;  offs = addr_i - MK1_BASE;
    end else if (addr_i < CTRL_ADDR) begin
      region = REG_EDGE; offs = addr_i - EDGE_BASE;
    end else if (addr_i == CTRL_ADDR) begin
      region = REG_CTRL;
    end
  end

  logic [1:0][SB-1:0] st_rd_hit, st_wr_hit, mk_wr_hit;
  logic [EB-1:0]      edge_wr_hit;
  logic               ctrl_wr_hit;
  always_comb begin
    for (int b = 0; b < SB; b++) begin
      st_rd_hit[0][b] = rd_en_i && region == REG_ST0 && offs == ADDR_W'(b);
      st_rd_hit[1][b] = rd_en_i && region == REG_ST1 && offs == ADDR_W'(b);
      st_wr_hit[0][b] = wr_en_i && region == REG_ST0 && offs == ADDR_W'(b);
      st_wr_hit[1][b] = wr_en_i && region == REG_ST1 && offs == ADDR_W'(b);
      mk_wr_hit[0][b] = wr_en_i && region == REG_MK0 && offs == ADDR_W'(b);
      mk_wr_hit[1][b] = wr_en_i && region == REG_MK1 && offs == ADDR_W'(b);
    end
    for (int b = 0; b < EB; b++) begin
      edge_wr_hit[b] = wr_en_i && region == REG_EDGE && offs == ADDR_W'(b);
    end
    ctrl_wr_hit = wr_en_i && region == REG_CTRL;
  end

  // acknowledge mode
  logic cor_q, cor_n;
  always_comb cor_n = ctrl_wr_hit ? wdata_i[COR_BIT] : cor_q;
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) cor_q <= 1'b0;
    else        cor_q <= cor_n;
  end

  // edge detection shared by both lines
  logic [2*N_SRC-1:0] sel_w;
  logic [N_SRC-1:0]   ev_w;
  irq_edge_unit #(.N_SRC(N_SRC), .EB(EB)) edge_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .src_i   (src_i),
    .wr_be_i (edge_wr_hit),
    .wdata_i (wdata_i),
    .sel_o   (sel_w),
    .ev_o    (ev_w)
  );

  // per-line status and mask
  logic [1:0][N_SRC-1:0] st_w, mk_w, st_clr;
  always_comb begin
    for (int l = 0; l < 2; l++) begin
      for (int i = 0; i < N_SRC; i++) begin
        st_clr[l][i] = cor_q ? (st_rd_hit[l][i / 8] & st_w[l][i])
                             : (st_wr_hit[l][i / 8] & wdata_i[i % 8]);
      end
    end
  end

  for (genvar l = 0; l < 2; l++) begin : g_line
    irq_line_slice #(.N_SRC(N_SRC), .NB(SB)) line_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_n),
      .ev_i    (ev_w),
      .clr_i   (st_clr[l]),
      .mk_be_i (mk_wr_hit[l]),
      .wdata_i (wdata_i),
      .st_o    (st_w[l]),
      .mk_o    (mk_w[l]),
      .irq_no  (irq_no[l])
    );
  end

  // read path
  logic [1:0][ST_PAD-1:0] st_p, mk_p;
  logic [EG_PAD-1:0]      sel_p;
  assign st_p[0] = ST_PAD'(st_w[0]);
  assign st_p[1] = ST_PAD'(st_w[1]);
  assign mk_p[0] = ST_PAD'(mk_w[0]);
  assign mk_p[1] = ST_PAD'(mk_w[1]);
  assign sel_p   = EG_PAD'(sel_w);

  logic [7:0] rd_byte, rdata_q, rdata_n;
  always_comb begin
    rd_byte = '0;
    case (region)
      REG_ST0, REG_ST1: begin
        for (int b = 0; b < SB; b++)
          if (offs == ADDR_W'(b)) rd_byte = st_p[region == REG_ST1][b*8 +: 8];
      end
      REG_MK0, REG_MK1: begin
        for (int b = 0; b < SB; b++)
          if (offs == ADDR_W'(b)) rd_byte = mk_p[region == REG_MK1][b*8 +: 8];
      end
      REG_EDGE: begin
        for (int b = 0; b < EB; b++)
          if (offs == ADDR_W'(b)) rd_byte = sel_p[b*8 +: 8];
      end
      REG_CTRL: rd_byte = {7'b0, cor_q};
      default:  rd_byte = '0;
    endcase
    rdata_n = rd_en_i ? rd_byte : rdata_q;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_n;
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/irq_bank_chk.sv
module irq_bank_chk #(
  parameter int N_SRC = 18
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  rd_en_i,
  input logic                  wr_en_i,
  input logic                  cor_i,
  input logic [2*N_SRC-1:0]    sel_i,
  input logic [N_SRC-1:0]      ev_i,
  input logic [1:0][N_SRC-1:0] st_i,
  input logic [1:0][N_SRC-1:0] mk_i,
  input logic [1:0]            irq_ni,
  input logic [7:0]            rdata_i
);

  assert_rdata_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_i));

  for (genvar l = 0; l < 2; l++) begin : g_l
    assert_full_mask_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (&mk_i[l]) |-> irq_ni[l]);

    for (genvar i = 0; i < N_SRC; i++) begin : g_i
      assert_disabled_src_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!wr_en_i && sel_i[2*i+1 -: 2] == 2'b00 && !st_i[l][i]) |=> !st_i[l][i]);

      assert_edge_not_lost_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ev_i[i] |=> st_i[l][i]);

      assert_status_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!rd_en_i && !wr_en_i && st_i[l][i]) |=> st_i[l][i]);

      assert_cor_write_ignored_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cor_i && wr_en_i && !rd_en_i && st_i[l][i]) |=> st_i[l][i]);
    end
  end

endmodule

bind irq_bank_ctrl irq_bank_chk #(.N_SRC(N_SRC)) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_n),
  .rd_en_i (rd_en_i),
  .wr_en_i (wr_en_i),
  .cor_i   (cor_q),
  .sel_i   (sel_w),
  .ev_i    (ev_w),
  .st_i    (st_w),
  .mk_i    (mk_w),
  .irq_ni  (irq_no),
  .rdata_i (rdata_o)
);

// File: tb/irq_bank_ctrl_tb_top.sv
module irq_bank_ctrl_tb_top;

  localparam int OP_WR  = 1;
  localparam int OP_RD  = 2;
  localparam int OP_SRC = 3;
  localparam int OP_IRQ = 4;

  function automatic logic [43:0] v(input int op, input int req, input int a,
                                    input int d, input int e);
    return {4'(op), 4'(req), 8'(a), 20'(d), 8'(e)};
  endfunction

  localparam int NV = 52;
  localparam logic [43:0] VEC [NV] = '{
    v(OP_RD, 8, 17, 0, 'h00),        // R8 control
    v(OP_RD, 8, 6, 0, 'hFF),         // R8 mask line 0
    v(OP_RD, 8, 8, 0, 'h03),         // R8 top mask byte, R7 padding
    v(OP_RD, 8, 12, 0, 'h00),        // R8 edge select
    v(OP_RD, 8, 0, 0, 'h00),         // R8 status
    v(OP_IRQ, 8, 0, 0, 'h03),        // R8 outputs idle
    v(OP_WR, 1, 12, 'h02, 0),        // R1 src0 rising
    v(OP_SRC, 1, 0, 'h1, 0),         // R1
    v(OP_RD, 1, 0, 0, 'h01),         // R1 line 0
    v(OP_RD, 10, 3, 0, 'h01),        // R10 line 1 also set
    v(OP_IRQ, 3, 0, 0, 'h03),        // R3 masked
    v(OP_WR, 3, 6, 'hFE, 0),         // R3 unmask src0 line 0
    v(OP_IRQ, 3, 0, 0, 'h02),        // R3 line 0 low only
    v(OP_RD, 4, 0, 0, 'h01),         // R4 read does not clear
    v(OP_WR, 5, 0, 'h01, 0),         // R5 write one clears
    v(OP_RD, 5, 0, 0, 'h00),         // R5
    v(OP_IRQ, 5, 0, 0, 'h03),        // R5
    v(OP_SRC, 1, 0, 'h0, 0),         // R1 falling with rising-only field
    v(OP_RD, 1, 0, 0, 'h00),         // R1
    v(OP_WR, 1, 13, 'h04, 0),        // R1 src5 falling only
    v(OP_SRC, 1, 0, 'h20, 0),        // R1
    v(OP_RD, 1, 0, 0, 'h00),         // R1 rising ignored
    v(OP_SRC, 1, 0, 'h0, 0),         // R1
    v(OP_RD, 1, 0, 0, 'h20),         // R1 falling seen
    v(OP_WR, 1, 16, 'h0C, 0),        // R1 src17 both edges
    v(OP_SRC, 1, 0, 'h20000, 0),     // R1
    v(OP_RD, 1, 2, 0, 'h02),         // R1 rising
    v(OP_WR, 5, 2, 'h02, 0),         // R5
    v(OP_SRC, 1, 0, 'h0, 0),         // R1
    v(OP_RD, 1, 2, 0, 'h02),         // R1 falling
    v(OP_WR, 5, 2, 'h02, 0),         // R5
    v(OP_SRC, 2, 0, 'h200, 0),       // R2 src9 field 00
    v(OP_SRC, 2, 0, 'h0, 0),         // R2
    v(OP_RD, 2, 1, 0, 'h00),         // R2 line 0
    v(OP_RD, 2, 4, 0, 'h00),         // R2 line 1
    v(OP_WR, 4, 17, 'h01, 0),        // R4 clear-on-read on
    v(OP_RD, 4, 17, 0, 'h01),        // R4
    v(OP_RD, 4, 0, 0, 'h20),         // R4
    v(OP_RD, 4, 0, 0, 'h00),         // R4 cleared by read
    v(OP_RD, 10, 3, 0, 'h21),        // R10 line 1 untouched
    v(OP_RD, 4, 3, 0, 'h00),         // R4
    v(OP_WR, 5, 5, 'h02, 0),         // R5 write ignored in read mode
    v(OP_RD, 5, 5, 0, 'h02),         // R5
    v(OP_RD, 4, 5, 0, 'h00),         // R4
    v(OP_WR, 5, 17, 'h00, 0),        // R5 back to write-clear
    v(OP_RD, 7, 16, 0, 'h0C),        // R7
    v(OP_WR, 7, 16, 'hFF, 0),        // R7
    v(OP_RD, 7, 16, 0, 'h0F),        // R7 unused bits read zero
    v(OP_WR, 7, 16, 'h00, 0),        // R7
    v(OP_RD, 7, 8, 0, 'h03),         // R7
    v(OP_RD, 10, 9, 0, 'hFF),        // R10 line 1 mask untouched
    v(OP_RD, 7, 6, 0, 'hFE)          // R7
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [17:0] src;
  logic        rd_en, wr_en;
  logic [4:0]  addr;
  logic [7:0]  wdata;
  logic [7:0]  rdata;
  logic [1:0]  irq_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  irq_bank_ctrl dut_i (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .src_i   (src),
    .rd_en_i (rd_en),
    .wr_en_i (wr_en),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .irq_no  (irq_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_wr(input int a, input int d);
    wr_en = 1'b1; addr = 5'(a); wdata = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_rd(input int a, output logic [7:0] d);
    rd_en = 1'b1; addr = 5'(a);
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic set_src(input int s);
    src = 18'(s);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] rb;
    rst_n = 1'b0; src = '0; rd_en = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      logic [3:0]  op;
      logic [3:0]  rq;
      logic [7:0]  a;
      logic [19:0] d;
      logic [7:0]  e;
      {op, rq, a, d, e} = VEC[k];
      case (int'(op))
        OP_WR:  do_wr(int'(a), int'(d));
        OP_RD: begin
          do_rd(int'(a), rb);
          chk($sformatf("R%0d vec%0d read", rq, k), 32'(rb), 32'(e));
        end
        OP_SRC: set_src(int'(d));
        OP_IRQ: chk($sformatf("R%0d vec%0d irq", rq, k), 32'(irq_n), 32'(e[1:0]));
        default: ;
      endcase
    end

    // R6: edge together with a write-one clear
    set_src(1);
    set_src(0);
    wr_en = 1'b1; addr = 5'd0; wdata = 8'h01; src = 18'h1;
    @(negedge clk);
    wr_en = 1'b0;
    do_rd(0, rb); chk("R6 edge kept over write clear", 32'(rb), 32'h01);
    do_wr(0, 'h01);
    do_rd(0, rb); chk("R5 cleared after write", 32'(rb), 32'h00);

    // R6: edge together with a clear-on-read
    do_wr(17, 'h01);
    set_src(0);
    set_src(1);
    set_src(0);
    rd_en = 1'b1; addr = 5'd0; src = 18'h1;
    @(negedge clk);
    rd_en = 1'b0;
    chk("R6 read returns set bit", 32'(rdata), 32'h01);
    do_rd(0, rb); chk("R6 edge kept over read clear", 32'(rb), 32'h01);
    do_rd(0, rb); chk("R4 cleared after read", 32'(rb), 32'h00);

    // R9: read data holds
    do_rd(17, rb);
    set_src(0);
    repeat (3) @(negedge clk);
    chk("R9 rdata held", 32'(rdata), 32'h01);

    // R3 and R10: line 1 output only
    do_wr(9, 'hFE);
    chk("R3 line1 asserted alone", 32'(irq_n), 32'h1);
    do_wr(9, 'hFF);
    chk("R3 line1 masked again", 32'(irq_n), 32'h3);

    // R8: reset in mid-run
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8 irq during reset", 32'(irq_n), 32'h3);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    do_rd(17, rb); chk("R8 control after reset", 32'(rb), 32'h00);
    do_rd(6, rb);  chk("R8 mask after reset", 32'(rb), 32'hFF);
    do_rd(12, rb); chk("R8 edge after reset", 32'(rb), 32'h00);
    do_rd(3, rb);  chk("R8 status after reset", 32'(rb), 32'h00);

    finish_run();
  end

endmodule